// File: doc/BRIEF.md
# Dual-Mode Serial Configuration Loader for a 16-Channel LED Sink

This block receives the configuration of a sixteen-channel constant-current LED sink over a three-wire serial link (data, shift clock, latch) plus a mode select. All serial pins are sampled in the fast system clock domain. Rising edges of the shift clock move one bit into the shift register that the mode select chooses, most significant bit first. The last bit of that register drives a serial output, so several loaders can be chained by feeding one serial output into the next data input.

With the mode select low, a 16-bit shift register feeds a per-channel on/off register. That register loads only on a rising edge of the latch input. With the mode select high, a 112-bit shift register feeds the brightness-correction register, which holds a 7-bit word per channel. That register is transparent while the latch input is high and keeps its value while the latch input is low. Shift clocks that arrive while it is transparent are discarded so that its contents stay steady. The on/off vector and the sixteen correction words are available as parallel outputs. The blanking state of the outputs plays no part in loading either register.

Top module: `led_cfg_loader`

## Requirements
- R1: After reset the on/off outputs, all correction words, both shift registers and the serial output are zero.
- R2: In on/off mode (mode select = 0) the 16 bits most recently shifted in, first bit = channel 15 down to last bit = channel 0, appear on `chan_on_o[15:0]` after a latch rising edge.
- R3: The on/off register changes only on a latch rising edge in on/off mode. Shifting without a latch edge, or with the latch held high, leaves it unchanged.
- R4: In correction mode (mode select = 1) a 112-bit transfer sets all sixteen words together: channel n is taken from shift-register bits [7n+6:7n] and appears on `chan_dc_o[7n+6:7n]`, so channel 15 is sent first, MSB first.
- R5: The correction register follows its shift register while the latch is high in correction mode and holds its value while the latch is low.
- R6: Shift clocks seen while the latch is high in correction mode do not change the correction shift register, the serial output or the correction outputs.
- R7: The serial output equals the last bit of the active shift register (bit 15 in on/off mode, bit 111 in correction mode), so each input bit emerges 16 or 112 shifts later.
- R8: Shifting in one mode leaves the other mode's shift register unchanged, which is visible on the serial output after the mode is switched back.
- R9: A latch operation in one mode leaves the other mode's output register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, samples all serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock, a bit is taken on its rising edge |
| ser_din_i | input | 1 | Serial data input, MSB first |
| latch_i | input | 1 | Latch control: edge in on/off mode, level in correction mode |
| mode_i | input | 1 | 0 = on/off mode (16 bits), 1 = correction mode (112 bits) |
| ser_dout_o | output | 1 | Last bit of the active shift register, for chaining |
| chan_on_o | output | 16 | Latched on/off bit per channel |
| chan_dc_o | output | 112 | Latched 7-bit correction word per channel, channel n at [7n+6:7n] |

## Verification
The hardest case to reach from the ports is a run of shift clocks that arrives while the correction register is transparent. Those pulses must leave the correction shift register untouched. That register has no port of its own and can only be seen through the serial output and through later latch operations. The bench keeps the latch high in correction mode and clocks in bits of the opposite value. It then checks that the serial output and the correction outputs have not moved. Finally, a later latch with no new shifts must reproduce the earlier words. A separate test switches modes between transfers to show that each shift register keeps its contents while the other mode is active.

// File: rtl/led_cfg_pkg.sv
package led_cfg_pkg;

   localparam int unsigned CH_DEFAULT   = 16;
   localparam int unsigned DCW_DEFAULT  = 7;
   localparam int unsigned SYNC_DEFAULT = 2;

   typedef enum logic {
      SEL_ONOFF = 1'b0,
      SEL_DC    = 1'b1
   } cfg_sel_e;

   function automatic int unsigned dc_total_bits(input int unsigned ch, input int unsigned w);
      return ch * w;
   endfunction

endpackage

// File: rtl/led_cfg_sync.sv
module led_cfg_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < int'(STAGES); i++) begin
            chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/led_cfg_shreg.sv
module led_cfg_shreg #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_en,
   input  logic         din,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (shift_en) begin
         q <= {q[W-2:0], din};
      end
   end

endmodule

// File: rtl/led_cfg_regs.sv
module led_cfg_regs
   import led_cfg_pkg::*;
#(
   parameter int unsigned NUM_CH = CH_DEFAULT,
   parameter int unsigned DC_W   = DCW_DEFAULT,
   localparam int unsigned DC_BITS = NUM_CH * DC_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  cfg_sel_e           sel,
   input  logic               xlat_lvl,
   input  logic               xlat_rise,
   input  logic [NUM_CH-1:0]  oo_sr,
   input  logic [DC_BITS-1:0] dc_sr,
   output logic [NUM_CH-1:0]  on_q,
   output logic [DC_BITS-1:0] dc_q
);

   logic oo_load;
   logic dc_open;

   assign oo_load = (sel == SEL_ONOFF) && xlat_rise;
   assign dc_open = (sel == SEL_DC) && xlat_lvl;

   for (genvar c = 0; c < int'(NUM_CH); c++) begin : g_ch
      logic            on_r;
      logic [DC_W-1:0] word_r;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            on_r <= 1'b0;
         end else if (oo_load) begin
            on_r <= oo_sr[c];
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_r <= '0;
         end else if (dc_open) begin
            word_r <= dc_sr[c*DC_W +: DC_W];
         end
      end

      assign on_q[c]               = on_r;
      assign dc_q[c*DC_W +: DC_W]  = word_r;
   end

endmodule

// File: rtl/led_cfg_loader.sv
module led_cfg_loader
   import led_cfg_pkg::*;
#(
   parameter int unsigned NUM_CH      = CH_DEFAULT,
   parameter int unsigned DC_W        = DCW_DEFAULT,
   parameter int unsigned SYNC_STAGES = SYNC_DEFAULT,
   localparam int unsigned DC_BITS    = NUM_CH * DC_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ser_clk_i,
   input  logic               ser_din_i,
   input  logic               latch_i,
   input  logic               mode_i,
   output logic               ser_dout_o,
   output logic [NUM_CH-1:0]  chan_on_o,
   output logic [DC_BITS-1:0] chan_dc_o
);

   if (NUM_CH < 2) begin : g_bad_ch
      $error("led_cfg_loader: NUM_CH must be at least 2");
   end
   if (DC_W < 1) begin : g_bad_w
      $error("led_cfg_loader: DC_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("led_cfg_loader: SYNC_STAGES must be at least 2");
   end
   if (DC_BITS != dc_total_bits(NUM_CH, DC_W)) begin : g_bad_len
      $error("led_cfg_loader: correction length mismatch");
   end

   logic [3:0] pins_s;
   logic       sclk_s, sin_s, xlat_s, mode_s;
   logic       sclk_d, xlat_d;
   logic       sclk_rise, xlat_rise;
   logic       oo_shift, dc_shift;
   cfg_sel_e   sel;
   logic [NUM_CH-1:0]  oo_sr;
   logic [DC_BITS-1:0] dc_sr;

   led_cfg_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({mode_i, latch_i, ser_din_i, ser_clk_i}),
      .q     (pins_s)
   );

   assign {mode_s, xlat_s, sin_s, sclk_s} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         xlat_d <= 1'b0;
      end else begin
         sclk_d <= sclk_s;
         xlat_d <= xlat_s;
      end
   end

   assign sclk_rise = sclk_s & ~sclk_d;
   assign xlat_rise = xlat_s & ~xlat_d;
   assign sel       = mode_s ? SEL_DC : SEL_ONOFF;
   assign oo_shift  = sclk_rise && (sel == SEL_ONOFF);
   assign dc_shift  = sclk_rise && (sel == SEL_DC) && !xlat_s;

   led_cfg_shreg #(.W(NUM_CH)) u_oo_sr (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (oo_shift),
      .din      (sin_s),
      .q        (oo_sr)
   );

   led_cfg_shreg #(.W(DC_BITS)) u_dc_sr (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (dc_shift),
      .din      (sin_s),
      .q        (dc_sr)
   );

   led_cfg_regs #(.NUM_CH(NUM_CH), .DC_W(DC_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (sel),
      .xlat_lvl  (xlat_s),
      .xlat_rise (xlat_rise),
      .oo_sr     (oo_sr),
      .dc_sr     (dc_sr),
      .on_q      (chan_on_o),
      .dc_q      (chan_dc_o)
   );

   assign ser_dout_o = (sel == SEL_DC) ? dc_sr[DC_BITS-1] : oo_sr[NUM_CH-1];

endmodule

// File: rtl/led_cfg_loader_chk.sv
module led_cfg_loader_chk #(
   parameter int unsigned NUM_CH  = 16,
   parameter int unsigned DC_W    = 7,
   localparam int unsigned DC_BITS = NUM_CH * DC_W
) (
   input logic               clk,
   input logic               rst_n,
   input logic               mode_s,
   input logic               xlat_s,
   input logic [NUM_CH-1:0]  oo_sr,
   input logic [DC_BITS-1:0] dc_sr,
   input logic [NUM_CH-1:0]  chan_on_o,
   input logic [DC_BITS-1:0] chan_dc_o
);

   AST_ONOFF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_s && xlat_s && !$past(xlat_s)) |=> (chan_on_o == $past(oo_sr))); // R2

   AST_ONOFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mode_s && xlat_s && !$past(xlat_s)) |=> $stable(chan_on_o)); // R3

   AST_DC_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_s && xlat_s) |=> (chan_dc_o == $past(dc_sr))); // R5

   AST_DC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(mode_s && xlat_s) |=> $stable(chan_dc_o)); // R5

   AST_DC_SR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_s && xlat_s) |=> $stable(dc_sr)); // R6

   AST_OO_SR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      mode_s |=> $stable(oo_sr)); // R8

   AST_DC_SR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_s |=> $stable(dc_sr)); // R8

endmodule

bind led_cfg_loader led_cfg_loader_chk #(.NUM_CH(NUM_CH), .DC_W(DC_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode_s    (mode_s),
   .xlat_s    (xlat_s),
   .oo_sr     (oo_sr),
   .dc_sr     (dc_sr),
   .chan_on_o (chan_on_o),
   .chan_dc_o (chan_dc_o)
);

// File: tb/led_cfg_loader_tb_top.sv
module led_cfg_loader_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NCH  = 16;
   localparam int DCW  = 7;
   localparam int DCB  = NCH * DCW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0;
   logic ser_din = 1'b0;
   logic latch = 1'b0;
   logic mode = 1'b0;
   logic ser_dout;
   logic [NCH-1:0] chan_on;
   logic [DCB-1:0] chan_dc;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   logic [NCH-1:0] oo_m = '0;
   logic [DCB-1:0] dc_m = '0;
   logic [NCH-1:0] on_m = '0;
   logic [DCB-1:0] dco_m = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   led_cfg_loader dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .ser_clk_i  (ser_clk),
      .ser_din_i  (ser_din),
      .latch_i    (latch),
      .mode_i     (mode),
      .ser_dout_o (ser_dout),
      .chan_on_o  (chan_on),
      .chan_dc_o  (chan_dc)
   );

   task automatic hold(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic check_regs(input string tag);
      chk(chan_on === on_m, {tag, " on/off"}, 128'(chan_on), 128'(on_m));
      chk(chan_dc === dco_m, {tag, " correction"}, 128'(chan_dc), 128'(dco_m));
   endtask

   function automatic logic model_out();
      return mode ? dc_m[DCB-1] : oo_m[NCH-1];
   endfunction

   // one serial bit; serial output is compared with the model after every shift (R7)
   task automatic send_bit(input logic b);
      ser_din = b;
      hold(2);
      ser_clk = 1'b1;
      hold(4);
      ser_clk = 1'b0;
      hold(4);
      if (!mode) oo_m = {oo_m[NCH-2:0], b};
      else if (!latch) dc_m = {dc_m[DCB-2:0], b};
      chk(ser_dout === model_out(), "R7 serial out", 128'(ser_dout), 128'(model_out()));
   endtask

   task automatic send_onoff(input logic [NCH-1:0] w);
      for (int i = NCH - 1; i >= 0; i--) send_bit(w[i]);
   endtask

   task automatic send_dc(input logic [DCB-1:0] v);
      for (int i = DCB - 1; i >= 0; i--) send_bit(v[i]);
   endtask

   task automatic pulse_latch();
      latch = 1'b1;
      hold(6);
      if (mode) dco_m = dc_m;
      else on_m = oo_m;
      latch = 1'b0;
      hold(6);
   endtask

   task automatic set_mode(input logic m);
      mode = m;
      hold(5);
   endtask

   function automatic logic [DCB-1:0] dc_pattern(input int mul, input int add);
      logic [DCB-1:0] v = '0;
      for (int n = 0; n < NCH; n++) v[n*DCW +: DCW] = DCW'((n * mul + add) % 128);
      return v;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [DCB-1:0] pat;
      hold(4);
      rst_n = 1'b1;
      hold(4);

      // R1: reset state
      chk(chan_on === '0, "R1 on/off after reset", 128'(chan_on), 128'(0));
      chk(chan_dc === '0, "R1 correction after reset", 128'(chan_dc), 128'(0));
      chk(ser_dout === 1'b0, "R1 serial out after reset", 128'(ser_dout), 128'(0));

      // R2: walking one over every channel, then mixed words
      for (int i = 0; i < NCH; i++) begin
         send_onoff(NCH'(1) << i);
         pulse_latch();
         chk(chan_on === (NCH'(1) << i), "R2 walking one", 128'(chan_on), 128'(NCH'(1) << i));
      end
      send_onoff(16'hA5C3); pulse_latch(); check_regs("R2 word A5C3");
      send_onoff(16'hFFFF); pulse_latch(); check_regs("R2 all on");
      send_onoff(16'h0000); pulse_latch(); check_regs("R2 all off");

      // R3: no latch edge, latch held high, then a new edge
      send_onoff(16'h1234); pulse_latch();
      send_onoff(16'h4321);
      chk(chan_on === 16'h1234, "R3 shift without latch", 128'(chan_on), 128'h1234);
      latch = 1'b1; hold(6); on_m = oo_m;
      chk(chan_on === 16'h4321, "R3 rising edge loads", 128'(chan_on), 128'h4321);
      send_onoff(16'hBEEF);
      chk(chan_on === 16'h4321, "R3 shifting with latch high", 128'(chan_on), 128'h4321);
      latch = 1'b0; hold(6);
      chk(chan_on === 16'h4321, "R3 latch fall", 128'(chan_on), 128'h4321);
      pulse_latch();
      chk(chan_on === 16'hBEEF, "R3 next edge", 128'(chan_on), 128'hBEEF);

      // R8: correction shift register untouched by on/off traffic
      set_mode(1'b1);
      chk(ser_dout === 1'b0, "R8 correction register idle", 128'(ser_dout), 128'(0));

      // R4 / R5: full transfer, hold until latch, then per-channel mapping
      pat = dc_pattern(37, 11);
      send_dc(pat);
      check_regs("R5 hold while latch low");
      pulse_latch();
      for (int n = 0; n < NCH; n++)
         chk(chan_dc[n*DCW +: DCW] === pat[n*DCW +: DCW], $sformatf("R4 channel %0d", n),
             128'(chan_dc[n*DCW +: DCW]), 128'(pat[n*DCW +: DCW]));
      chk(chan_on === 16'hBEEF, "R9 correction latch keeps on/off", 128'(chan_on), 128'hBEEF);

      // R6: shift clocks while transparent are dropped
      latch = 1'b1; hold(6);
      for (int i = 0; i < 8; i++) send_bit(~dc_m[DCB-1]);
      check_regs("R6 clocks while transparent");
      latch = 1'b0; hold(6);
      chk(ser_dout === pat[DCB-1], "R6 serial out after frozen clocks", 128'(ser_dout), 128'(pat[DCB-1]));
      pulse_latch();
      chk(chan_dc === pat, "R6 relatch unchanged", chan_dc[DCB-1:0], pat);

      // R5: transparent while high, held after fall
      pat = dc_pattern(5, 100);
      send_dc(pat);
      check_regs("R5 held before latch");
      latch = 1'b1; hold(6); dco_m = dc_m;
      chk(chan_dc === pat, "R5 transparent", chan_dc, pat);
      latch = 1'b0; hold(6);
      chk(chan_dc === pat, "R5 held after fall", chan_dc, pat);

      // R8 / R9: mode switch keeps the other side's state
      set_mode(1'b0);
      chk(ser_dout === oo_m[NCH-1], "R8 on/off register kept", 128'(ser_dout), 128'(oo_m[NCH-1]));
      send_onoff(16'h5AA5); pulse_latch();
      check_regs("R9 on/off latch keeps correction");
      set_mode(1'b1);
      chk(ser_dout === pat[DCB-1], "R8 correction register kept", 128'(ser_dout), 128'(pat[DCB-1]));

      // R4 boundaries: all full scale, alternating zero / full scale
      send_dc({DCB{1'b1}}); pulse_latch(); check_regs("R4 full scale");
      pat = '0;
      for (int n = 0; n < NCH; n += 2) pat[n*DCW +: DCW] = '1;
      send_dc(pat); pulse_latch(); check_regs("R4 alternating");
      send_dc('0); pulse_latch(); check_regs("R4 all zero");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule